// File: doc/BRIEF.md
# Looping Longest-Prefix Lookup Engine

This block resolves the longest matching route prefix for 32-bit IPv4 addresses. The routing data is a four-level trie held in one external read memory. That memory has a fixed read latency of `MEM_LAT` cycles. Each address is walked one byte at a time. Every byte costs one memory read. A walk ends early when the fetched word is marked as a leaf.

Fixed-depth stages are not used. A lookup that still needs another level goes back through a small recirculation queue and reuses the same memory port. Deep and shallow lookups therefore share the memory bandwidth, and the port stays busy whenever there is work.

Each admitted address receives a sequence tag. Its result is written into a completion buffer at that tag. Results are released strictly in tag order, so they leave in the order the addresses arrived.

Memory word format:
- Bit 31 set: the word is a leaf, and bits 15:0 hold the next hop.
- Bit 31 clear: the word is a branch, and its low bits hold the base of the child table.

Top module: `lpm_loop_engine`

## Requirements
- R1: When an address is admitted (`in_valid` and `in_ready` both high), the memory port issues a read in that same cycle, at address `in_addr[31:24]`.
- R2: Each read after the first goes to the child base from the previous word plus the next address byte, in this order: bits 23:16, then bits 15:8, then bits 7:0.
- R3: A fetched word with bit 31 set ends the lookup. Its bits 15:0 become the reported `out_hop`.
- R4: The word from the fourth read is always taken as a leaf, whatever its bit 31 holds. No lookup makes more than four reads.
- R5: While a lookup waits to recirculate, `in_ready` is low and that lookup takes the memory port.
- R6: While an address is offered and the engine is not full, or a recirculation is waiting, the memory port issues a read every cycle.
- R7: Results leave in exactly the order their addresses were admitted, whatever their lookup depths.
- R8: At most 2^`TAG_W` lookups can be admitted and not yet released. At that count `in_ready` is low.
- R9: During and right after reset, `in_ready` is 1, `out_valid` is 0 and `mem_rd_en` is 0.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_hop` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An address is offered |
| in_addr | input | 32 | IPv4 address to look up |
| in_ready | output | 1 | The engine admits the offered address this cycle |
| out_valid | output | 1 | The next in-order result is available |
| out_ready | input | 1 | The consumer takes the result |
| out_hop | output | 16 | Next-hop value of the result |
| mem_rd_en | output | 1 | Memory read issued this cycle |
| mem_addr | output | MEM_AW | Memory read address |
| mem_rdata | input | 32 | Read data, valid exactly MEM_LAT cycles after the request |

## Verification
The assertions assume three things about the environment:
- The memory returns data exactly `MEM_LAT` cycles after each read.
- Branch words point at child tables that fit inside the address space.
- `in_addr` stays steady while it is offered.

The bench models the memory as a register pipeline of that exact length. It builds a trie whose branch pointers sit on table boundaries, and it changes the address only after the engine has admitted it. Stimulus mixes one-, two-, three- and four-read walks. It includes a fourth-level word with bit 31 clear. It also holds `out_ready` low long enough to fill every tag.

// File: rtl/lpm_loop_engine.sv
module lpm_loop_engine #(
  parameter int MEM_AW  = 10,
  parameter int MEM_LAT = 3,
  parameter int TAG_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_addr,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [15:0]       out_hop,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [31:0]       mem_rdata
);
  localparam int DEPTH = 1 << TAG_W;
  localparam logic [TAG_W:0] DEPTH_CNT = (TAG_W+1)'(DEPTH);

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [1:0]        lvl;
    logic [31:0]       ip;
    logic [MEM_AW-1:0] ptr;
  } ctx_t;

  logic [TAG_W:0]   cb_wp, cb_rp, rq_wp, rq_rp;
  ctx_t             rq_mem [DEPTH];
  ctx_t             pipe_q [MEM_LAT];
  logic [MEM_LAT-1:0] pv_q;
  logic [15:0]      cb_hop [DEPTH];
  logic [DEPTH-1:0] cb_vld;

  logic rq_empty, rq_full, cb_full, take_in, release_out;
  logic rsp_v, rsp_leaf, rsp_done, rq_push;
  ctx_t iss, rsp, nxt;
  logic [7:0] slice;

  assign rq_empty    = rq_wp == rq_rp;
  assign rq_full     = (rq_wp - rq_rp) == DEPTH_CNT;
  assign cb_full     = (cb_wp - cb_rp) == DEPTH_CNT;
  assign in_ready    = rq_empty && !cb_full;
  assign take_in     = in_valid && in_ready;
  assign mem_rd_en   = !rq_empty || take_in;

  always_comb begin
    if (rq_empty) begin
      iss.tag = cb_wp[TAG_W-1:0];
      iss.lvl = 2'd0;
      iss.ip  = in_addr;
      iss.ptr = '0;
    end else begin
      iss = rq_mem[rq_rp[TAG_W-1:0]];
    end
    case (iss.lvl)
      2'd0:    slice = iss.ip[31:24];
      2'd1:    slice = iss.ip[23:16];
      2'd2:    slice = iss.ip[15:8];
      default: slice = iss.ip[7:0];
    endcase
  end

  assign mem_addr = (iss.lvl == 2'd0) ? MEM_AW'(slice) : iss.ptr + MEM_AW'(slice);

  assign rsp      = pipe_q[MEM_LAT-1];
  assign rsp_v    = pv_q[MEM_LAT-1];
  assign rsp_leaf = mem_rdata[31] || (rsp.lvl == 2'd3);
  assign rsp_done = rsp_v && rsp_leaf;
  assign rq_push  = rsp_v && !rsp_leaf;

  always_comb begin
    nxt     = rsp;
    nxt.lvl = rsp.lvl + 2'd1;
    nxt.ptr = mem_rdata[MEM_AW-1:0];
  end

  assign out_valid   = cb_vld[cb_rp[TAG_W-1:0]];
  assign out_hop     = cb_hop[cb_rp[TAG_W-1:0]];
  assign release_out = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cb_wp  <= '0;
      cb_rp  <= '0;
      rq_wp  <= '0;
      rq_rp  <= '0;
      pv_q   <= '0;
      cb_vld <= '0;
    end else begin
      if (take_in)             cb_wp <= cb_wp + 1'b1;
      if (release_out)         cb_rp <= cb_rp + 1'b1;
      if (rq_push)             rq_wp <= rq_wp + 1'b1;
      if (!rq_empty)           rq_rp <= rq_rp + 1'b1;
      pv_q[0] <= mem_rd_en;
      for (int i = 1; i < MEM_LAT; i++) pv_q[i] <= pv_q[i-1];
      if (release_out)         cb_vld[cb_rp[TAG_W-1:0]] <= 1'b0;
      if (rsp_done)            cb_vld[rsp.tag] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    pipe_q[0] <= iss;
    for (int i = 1; i < MEM_LAT; i++) pipe_q[i] <= pipe_q[i-1];
    if (rq_push)  rq_mem[rq_wp[TAG_W-1:0]] <= nxt;
    if (rsp_done) cb_hop[rsp.tag] <= mem_rdata[15:0];
  end

  assert_first_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> mem_rd_en && mem_addr == MEM_AW'(in_addr[31:24]));

  assert_recirc_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rq_empty |-> !in_ready && mem_rd_en);

  assert_tag_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !cb_vld[rsp.tag]);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rq_push |-> !rq_full);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_hop));
endmodule

// File: tb/lpm_loop_engine_tb_top.sv
module lpm_loop_engine_tb_top;
  localparam int MEM_AW = 10, MEM_LAT = 3, TAG_W = 4, DEPTH = 1 << TAG_W;

  logic clk = 0, rst_n = 0, in_valid = 0, out_ready = 0;
  logic [31:0] in_addr = '0;
  logic in_ready, out_valid, mem_rd_en;
  logic [15:0] out_hop;
  logic [MEM_AW-1:0] mem_addr;
  logic [31:0] mem_rdata;

  always #2 clk = ~clk;

  lpm_loop_engine #(.MEM_AW(MEM_AW), .MEM_LAT(MEM_LAT), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_hop(out_hop),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata));

  logic [31:0] tbl [1 << MEM_AW];
  logic [31:0] mp [MEM_LAT];
  always_ff @(posedge clk) begin
    mp[0] <= tbl[mem_addr];
    for (int i = 1; i < MEM_LAT; i++) mp[i] <= mp[i-1];
  end
  assign mem_rdata = mp[MEM_LAT-1];

  int checks = 0, bad = 0;
  int reads = 0, exp_reads = 0, accepted = 0, released = 0, stall_cnt = 0, idle_cnt = 0;
  logic [15:0] exp_q [$];
  bit finished = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ref_walk(input logic [31:0] a, output logic [15:0] hop, output int n);
    logic [31:0] w;
    logic [MEM_AW-1:0] p;
    w = tbl[a[31:24]]; n = 1;
    for (int l = 1; l < 4 && !w[31]; l++) begin
      p = w[MEM_AW-1:0] + MEM_AW'(a[31-8*l -: 8]);
      w = tbl[p]; n++;
    end
    hop = w[15:0];
  endtask

  task automatic send(input logic [31:0] a);
    logic [15:0] h; int n; bit acc;
    ref_walk(a, h, n);
    exp_q.push_back(h);
    exp_reads += n;
    in_valid = 1; in_addr = a;
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
    end while (!acc);
    in_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_rd_en) reads++;
    if (in_valid && !mem_rd_en) idle_cnt++;
    if (in_valid && !in_ready && (accepted - released) < DEPTH) stall_cnt++;
    if (in_valid && in_ready) begin
      chk(mem_addr == MEM_AW'(in_addr[31:24]), "R1 first read address", 32'(mem_addr), 32'(in_addr[31:24]));
      accepted++;
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected result", 32'(out_hop), 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(out_hop == e, "R3/R7 hop in order", 32'(out_hop), 32'(e));
      end
      released++;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] deep_addrs [8];
    logic [15:0] held;
    int a0, s0, r0;
    bit fork_done;
    for (int i = 0; i < 256; i++) begin
      tbl[i]       = 32'h8000_0000 | (32'h1000 + i);
      tbl[256 + i] = 32'h8000_0000 | (32'h2000 + i);
      tbl[512 + i] = 32'h8000_0000 | (32'h3000 + i);
      tbl[768 + i] = 32'h0000_4000 + i;
    end
    tbl[10]       = 32'd256;
    tbl[256 + 20] = 32'd512;
    tbl[512 + 30] = 32'd768;

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1, "R9 reset in_ready", 32'(in_ready), 1);
    chk(out_valid == 0, "R9 reset out_valid", 32'(out_valid), 0);
    chk(mem_rd_en == 0, "R9 reset mem_rd_en", 32'(mem_rd_en), 0);
    @(posedge clk); #1; rst_n = 1; out_ready = 1;
    @(negedge clk);
    chk(out_valid == 0 && mem_rd_en == 0, "R9 after reset idle", {out_valid, mem_rd_en}, 0);

    // R2 R3 R4: single walks of each depth, including the fourth-level word with bit 31 clear
    @(posedge clk); #1;
    send(32'h0A14_1E07); send(32'h0A14_0500); send(32'h0A05_0000); send(32'h3300_0000);
    drain();
    chk(reads == exp_reads, "R2/R4 total memory reads", reads, exp_reads);

    // R5 R6: one deep walk followed by a steady stream of one-read walks
    s0 = stall_cnt; idle_cnt = 0;
    send(32'h0A14_1EFF);
    for (int i = 0; i < 12; i++) send(32'h4000_0000 + (i << 24));
    drain();
    chk(stall_cnt - s0 == 3, "R5 cycles taken by recirculation", stall_cnt - s0, 3);
    chk(idle_cnt == 0, "R6 no idle port while offered", idle_cnt, 0);
    chk(reads == exp_reads, "R4 reads after stream", reads, exp_reads);

    // R8 R10: consumer stalled, offer more than the tag count
    out_ready = 0; a0 = accepted; fork_done = 0;
    fork
      begin
        for (int i = 0; i < DEPTH + 4; i++) send(32'h0A14_0000 + (i << 8));
        fork_done = 1;
      end
    join_none
    repeat (80) @(posedge clk);
    @(negedge clk);
    chk(accepted - a0 == DEPTH, "R8 admitted while stalled", accepted - a0, DEPTH);
    chk(in_ready == 0, "R8 in_ready low when full", 32'(in_ready), 0);
    chk(out_valid == 1, "R10 result waiting", 32'(out_valid), 1);
    held = out_hop;
    repeat (5) @(negedge clk);
    chk(out_valid == 1 && out_hop == held, "R10 held result stable", 32'(out_hop), 32'(held));
    @(posedge clk); #1; out_ready = 1;
    wait (fork_done);
    drain();
    chk(exp_q.size() == 0, "R8 all stalled lookups released", exp_q.size(), 0);

    // R7: mixed depths back to back
    deep_addrs = '{32'h0A14_1E01, 32'h5500_0000, 32'h0A14_0302, 32'h0A07_0000,
                   32'h0A14_1E80, 32'h0100_0000, 32'h0A14_1EC3, 32'h0A99_0000};
    r0 = released;
    for (int k = 0; k < 3; k++)
      foreach (deep_addrs[i]) send(deep_addrs[i] ^ (k << 0));
    drain();
    chk(released - r0 == 24, "R7 mixed stream count", released - r0, 24);
    chk(reads == exp_reads, "R2/R4 final read total", reads, exp_reads);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule